// File: doc/BRIEF.md
# PWM Fault and Retrigger Input Conditioner

This block prepares one external control signal for a two-channel PWM core. Each channel (index 0 and 1) picks its own source: the digital pin or an already-digital comparator output. The chosen source is synchronized and can then pass through a persistence filter. After that, the channel's polarity and sensitivity settings are applied. The result is a retrigger strobe or a fault indication, registered in the PWM clock domain, which the counter and waveform logic use.

A separate combinational path does not depend on the clock. When a channel enables it and that channel's raw selected input sits at its active level, the path pulls a shared output-disable line. External drivers can then be made safe even if the PWM clock is stopped or disturbed. The synchronous path keeps working at the same time whenever the clock runs.

Top module: `pwm_input_cond`

## Requirements
- R1: `src_sel[i]`=0 takes channel i from `pin_in`, =1 from `cmp_in`. Activity on the source that is not selected produces no event on that channel.
- R2: With the filter off, the synchronous path is two synchronizer flops followed by one output register. A change on the selected source shows on `retrig`/`fault` after the 3rd rising clock edge.
- R3: With `filt_en[i]`=1, the conditioned signal changes only after the synchronized input has held a new value for 4 consecutive clocks. A pulse of 1 to 3 clocks produces no event, and a longer pulse shows its event after the 7th edge.
- R4: The input is active when it equals `act_lvl[i]` (1 = active high, 0 = active low).
- R5: With `edge_sens[i]`=1, an event is a one-clock strobe on entry into the active level.
- R6: With `edge_sens[i]`=0, the output follows the conditioned active state and stays high for every cycle that it is active.
- R7: `mode_sel` is 4 bits per channel (channel i at bits 4i+3..4i): 1 = retrigger on `retrig`, 2 = fault that drops by itself on `fault`, 3 = latched fault on `fault`. Value 0 and values 4 to 15 produce no events.
- R8: A latched fault stays set after the input goes inactive. It clears on a `fault_clr[i]` cycle only when the conditioned input is inactive, and a clear request while the input is active is ignored.
- R9: `async_off` is the combinational OR, over the channels, of (`async_en[i]` and raw selected input equal to `act_lvl[i]`). It responds with the clock stopped, and the synchronous events still occur with it enabled.
- R10: Synchronous reset clears the synchronizers, the filter, the edge history and the latched faults. `retrig` and `fault` read 0 after reset.
- R11: The two channels are independent, so an event on one channel produces nothing on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | synchronous active-high reset |
| pin_in | input | 1 | external pin input |
| cmp_in | input | 1 | comparator output, digital |
| src_sel | input | 2 | per-channel source select |
| filt_en | input | 2 | per-channel filter enable |
| act_lvl | input | 2 | per-channel active level |
| edge_sens | input | 2 | per-channel edge (1) or level (0) sensitivity |
| mode_sel | input | 8 | per-channel 4-bit action mode |
| async_en | input | 2 | per-channel asynchronous disable enable |
| fault_clr | input | 2 | per-channel latched-fault clear request |
| retrig | output | 2 | retrigger event per channel |
| fault | output | 2 | fault indication per channel |
| async_off | output | 1 | combinational output-disable request |

## Verification
Every source-select and polarity combination is driven with a step on the chosen source, and then with a step on the source that is not chosen. This separates the routing and polarity from the fixed three-edge latency and the one-cycle strobe width. The filter is given pulses of 1 to 6 clocks, which locates the exact persistence threshold and the seven-edge delay. Held pulses in level mode, a sweep of all non-action mode codes, a latch/clear sequence with the input held both active and inactive, and the clock-stopped disable path each isolate one of the remaining behaviours.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    ACT_NONE        = 4'd0,
    ACT_RETRIG      = 4'd1,
    ACT_FAULT_AUTO  = 4'd2,
    ACT_FAULT_LATCH = 4'd3
  } act_mode_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{rst_val}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pic_filter.sv
module pic_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          held_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= rst_val;
      run_q  <= '0;
    end else if (!en || d == held_q) begin
      held_q <= en ? held_q : d;
      run_q  <= '0;
    end else if (run_q == LAST) begin
      held_q <= d;
      run_q  <= '0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  assign q = en ? held_q : d;
endmodule

// File: rtl/pic_event.sv
module pic_event
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              edge_sens,
  input  logic [MODE_W-1:0] mode,
  input  logic              clr,
  output logic              retrig_q,
  output logic              fault_q
);
  logic act_hist_q, auto_q, latch_q;
  logic rise, trig;

  assign rise = active & ~act_hist_q;
  assign trig = edge_sens ? rise : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hist_q <= 1'b0;
      retrig_q   <= 1'b0;
      auto_q     <= 1'b0;
      latch_q    <= 1'b0;
    end else begin
      act_hist_q <= active;
      retrig_q   <= (mode == ACT_RETRIG) & trig;
      auto_q     <= (mode == ACT_FAULT_AUTO) & trig;
      if (mode != ACT_FAULT_LATCH) latch_q <= 1'b0;
      else if (trig)               latch_q <= 1'b1;
      else if (clr && !active)     latch_q <= 1'b0;
    end
  end

  assign fault_q = auto_q | latch_q;
endmodule

// File: rtl/pwm_input_cond.sv
module pwm_input_cond
  import pic_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_HOLD   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pin_in,
  input  logic                  cmp_in,
  input  logic [NCH-1:0]        src_sel,
  input  logic [NCH-1:0]        filt_en,
  input  logic [NCH-1:0]        act_lvl,
  input  logic [NCH-1:0]        edge_sens,
  input  logic [NCH*MODE_W-1:0] mode_sel,
  input  logic [NCH-1:0]        async_en,
  input  logic [NCH-1:0]        fault_clr,
  output logic [NCH-1:0]        retrig,
  output logic [NCH-1:0]        fault,
  output logic                  async_off
);
  logic [NCH-1:0] raw, synced, cond, active, raw_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign raw[i] = src_sel[i] ? cmp_in : pin_in;

    pic_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .rst_val(~act_lvl[i]),
      .d(raw[i]), .q(synced[i])
    );

    pic_filter #(.HOLD(FILT_HOLD)) filt_i (
      .clk(clk), .rst(rst), .rst_val(~act_lvl[i]), .en(filt_en[i]),
      .d(synced[i]), .q(cond[i])
    );

    assign active[i]  = (cond[i] == act_lvl[i]);
    assign raw_hit[i] = async_en[i] & (raw[i] == act_lvl[i]);

    pic_event evt_i (
      .clk(clk), .rst(rst), .active(active[i]), .edge_sens(edge_sens[i]),
      .mode(mode_sel[i*MODE_W +: MODE_W]), .clr(fault_clr[i]),
      .retrig_q(retrig[i]), .fault_q(fault[i])
    );
  end

  assign async_off = |raw_hit;
endmodule

// File: rtl/pwm_input_cond_chk.sv
module pwm_input_cond_chk
  import pic_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH-1:0]        edge_sens,
  input logic [NCH*MODE_W-1:0] mode_sel,
  input logic [NCH-1:0]        async_en,
  input logic [NCH-1:0]        fault_clr,
  input logic [NCH-1:0]        retrig,
  input logic [NCH-1:0]        fault,
  input logic                  async_off
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    p_strobe_width_r5: assert property (@(posedge clk) disable iff (rst)
      (retrig[i] && $past(retrig[i])) |-> !$past(edge_sens[i]));

    p_idle_mode_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_sel[i*MODE_W +: MODE_W]) == 4'd0 ||
       $past(mode_sel[i*MODE_W +: MODE_W]) > 4'd3) |-> (!retrig[i] && !fault[i]));

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (fault[i] && mode_sel[i*MODE_W +: MODE_W] == 4'd3 && !fault_clr[i]) |=> fault[i]);

    p_one_action_r6: assert property (@(posedge clk) disable iff (rst)
      !(retrig[i] && fault[i]));

    p_reset_clear_r10: assert property (@(posedge clk)
      $past(rst) |-> (!retrig[i] && !fault[i]));
  end

  p_async_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (async_en == '0) |-> !async_off);
endmodule

bind pwm_input_cond pwm_input_cond_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .edge_sens(edge_sens), .mode_sel(mode_sel),
  .async_en(async_en), .fault_clr(fault_clr), .retrig(retrig),
  .fault(fault), .async_off(async_off)
);

// File: tb/pwm_input_cond_tb_top.sv
module pwm_input_cond_tb_top;
  logic       clk = 1'b0, clk_run = 1'b1, rst = 1'b1;
  logic       pin_in = 1'b0, cmp_in = 1'b0;
  logic [1:0] src_sel = '0, filt_en = '0, act_lvl = 2'b11, edge_sens = 2'b11;
  logic [1:0] async_en = '0, fault_clr = '0;
  logic [7:0] mode_sel = '0;
  logic [1:0] retrig, fault;
  logic       async_off;
  int n_run = 0, n_fail = 0;

  pwm_input_cond dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_sel(src_sel), .filt_en(filt_en), .act_lvl(act_lvl),
    .edge_sens(edge_sens), .mode_sel(mode_sel), .async_en(async_en),
    .fault_clr(fault_clr), .retrig(retrig), .fault(fault),
    .async_off(async_off)
  );

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input bit sel, input bit fe, input bit lv,
                     input bit es, input logic [3:0] m);
    src_sel[ch] = sel; filt_en[ch] = fe; act_lvl[ch] = lv;
    edge_sens[ch] = es; mode_sel[ch*4 +: 4] = m;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic observe(input int ch, input int n, output int first,
                         output int nr, output int nf);
    first = -1; nr = 0; nf = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if ((retrig[ch] || fault[ch]) && first < 0) first = k;
      nr += int'(retrig[ch]);
      nf += int'(fault[ch]);
    end
  endtask

  initial begin
    int first, nr, nf, nb;
    settle(3);
    rst = 1'b0;
    @(negedge clk);
    check(retrig == 0 && fault == 0 && !async_off, "R10 reset state",
          int'({retrig, fault, async_off}), 0);

    // R1 R2 R4 R5: source and polarity sweep, bypass, edge retrigger
    for (int s = 0; s < 2; s++) begin
      for (int lv = 0; lv < 2; lv++) begin
        cfg(0, s[0], 1'b0, lv[0], 1'b1, 4'd1);
        pin_in = ~lv[0]; cmp_in = ~lv[0];
        settle(6);
        if (s == 0) pin_in = lv[0]; else cmp_in = lv[0];
        observe(0, 8, first, nr, nf);
        check(first == 3, "R2 bypass latency", first, 3);
        check(nr == 1, "R5 single strobe (R4 polarity)", nr, 1);
        if (s == 0) pin_in = ~lv[0]; else cmp_in = ~lv[0];
        settle(6);
        if (s == 0) cmp_in = lv[0]; else pin_in = lv[0];
        observe(0, 8, first, nr, nf);
        check(nr == 0 && nf == 0, "R1 unselected source ignored", nr + nf, 0);
        pin_in = ~lv[0]; cmp_in = ~lv[0];
        settle(6);
      end
    end

    // R3: filter threshold sweep
    cfg(0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1);
    pin_in = 1'b0; cmp_in = 1'b0;
    settle(10);
    for (int g = 1; g <= 6; g++) begin
      pin_in = 1'b1;
      first = -1; nr = 0;
      for (int k = 1; k <= 16; k++) begin
        @(negedge clk);
        if (retrig[0] && first < 0) first = k;
        nr += int'(retrig[0]);
        if (k == g) pin_in = 1'b0;
      end
      check(nr == ((g >= 4) ? 1 : 0), "R3 filter persistence", nr, (g >= 4) ? 1 : 0);
      if (g >= 4) check(first == 7, "R3 filter latency", first, 7);
      settle(8);
    end

    // R6: level sensitivity, auto fault and retrigger
    for (int m = 1; m <= 2; m++) begin
      cfg(0, 1'b0, 1'b0, 1'b1, 1'b0, 4'(m));
      pin_in = 1'b0;
      settle(6);
      pin_in = 1'b1;
      first = -1; nr = 0; nf = 0;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        nr += int'(retrig[0]);
        nf += int'(fault[0]);
        if (k == 5) pin_in = 1'b0;
      end
      check((m == 1) ? (nr == 5 && nf == 0) : (nf == 5 && nr == 0),
            "R6 level follow", nr + nf, 5);
    end

    // R7: non-action mode codes
    for (int m = 0; m < 16; m++) begin
      if (m >= 1 && m <= 3) continue;
      for (int e = 0; e < 2; e++) begin
        cfg(0, 1'b0, 1'b0, 1'b1, e[0], 4'(m));
        pin_in = 1'b0;
        settle(4);
        pin_in = 1'b1;
        observe(0, 6, first, nr, nf);
        pin_in = 1'b0;
        check(nr == 0 && nf == 0, "R7 mode produces nothing", nr + nf, 0);
      end
    end

    // R8: latched fault
    cfg(0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3);
    pin_in = 1'b0;
    settle(6);
    pin_in = 1'b1;
    settle(2);
    pin_in = 1'b0;
    settle(10);
    check(fault[0] == 1'b1, "R8 latch holds", int'(fault[0]), 1);
    pin_in = 1'b1;
    settle(4);
    fault_clr[0] = 1'b1;
    @(negedge clk);
    fault_clr[0] = 1'b0;
    settle(1);
    check(fault[0] == 1'b1, "R8 clear ignored while active", int'(fault[0]), 1);
    pin_in = 1'b0;
    settle(4);
    check(fault[0] == 1'b1, "R8 latch holds inactive", int'(fault[0]), 1);
    fault_clr[0] = 1'b1;
    @(negedge clk);
    fault_clr[0] = 1'b0;
    check(fault[0] == 1'b0, "R8 clear accepted", int'(fault[0]), 0);

    // R10: reset clears latch
    pin_in = 1'b1;
    settle(2);
    pin_in = 1'b0;
    settle(4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(fault == 0 && retrig == 0, "R10 reset clears latch", int'(fault), 0);
    settle(4);
    check(fault == 0, "R10 latch stays clear", int'(fault), 0);

    // R11: channel independence
    cfg(0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1);
    cfg(1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1);
    pin_in = 1'b0; cmp_in = 1'b0;
    settle(6);
    pin_in = 1'b1;
    nr = 0; nb = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      nr += int'(retrig[0]);
      nb += int'(retrig[1]) + int'(fault[1]);
    end
    check(nr == 1 && nb == 0, "R11 channels independent", nb, 0);
    pin_in = 1'b0;
    settle(6);

    // R9: async disable with clock stopped
    clk_run = 1'b0;
    #5;
    async_en = 2'b01; act_lvl = 2'b01; src_sel = 2'b10;
    pin_in = 1'b1; #5;
    check(async_off == 1'b1, "R9 async asserts", int'(async_off), 1);
    pin_in = 1'b0; #5;
    check(async_off == 1'b0, "R9 async releases", int'(async_off), 0);
    async_en = 2'b00; pin_in = 1'b1; #5;
    check(async_off == 1'b0, "R9 async disabled", int'(async_off), 0);
    pin_in = 1'b0; async_en = 2'b10; cmp_in = 1'b0; #5;
    check(async_off == 1'b1, "R9 channel 1 active low", int'(async_off), 1);
    cmp_in = 1'b1; #5;
    check(async_off == 1'b0, "R9 channel 1 inactive", int'(async_off), 0);
    async_en = 2'b01; act_lvl = 2'b11;
    clk_run = 1'b1;
    settle(6);
    pin_in = 1'b1;
    observe(0, 8, first, nr, nf);
    check(nr == 1 && async_off, "R9 sync path kept", nr, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule